// File: doc/BRIEF.md
# Gapped SPI Register-Access Sequencer

This block is an SPI master that runs one complete register access to a serial bus controller. A single start request sends an address byte, then a control byte, then between one and sixteen data bytes. Slave select stays low from before the first byte until after the last one. Before each byte and after the final one, the block holds an idle gap. Each gap is measured in periods of a separate reference oscillator, not in system clocks or SCK periods. Every phase boundary has its own minimum gap.

The reference oscillator arrives asynchronously and may run at up to about 8 MHz. The block synchronises it into the system clock domain and counts its rising edges. SCK is produced from the system clock by a programmable divider, so any SCK rate from 128 kHz up to 4 MHz can be reached. The data bytes shifted in on MISO are collected into a wide output word. A one-cycle done pulse marks the end of the access after slave select has been released.

Top module: `spi_gap_seq`

## Requirements
- R1: After reset, `ss_n` is 1, `sck` is 0, `busy` is 0 and `done` is 0.
- R2: A start while idle produces, under one low period of `ss_n`, the address byte, then the control byte, then `len_m1`+1 data bytes (`len_m1` is the count minus one, 0..15). Each byte is sent MSB first in SPI mode 0: SCK idles low, MISO is sampled on the rising edge and MOSI changes only while SCK is low.
- R3: `ss_n` falls exactly once and rises exactly once per transaction, and SCK is never high while `ss_n` is high.
- R4: Between the fall of `ss_n` and the first rising SCK edge of the address byte, at least 4 whole reference periods pass (at least 5 reference rising edges).
- R5: Between the last falling SCK edge of the address byte and the first rising edge of the control byte, at least 8 whole reference periods pass (at least 9 reference rising edges).
- R6: Between the control byte and the first data byte, at least 15 whole reference periods pass (at least 16 reference rising edges).
- R7: After every data byte, at least 12 whole reference periods pass (at least 13 reference rising edges) before the next data byte or before `ss_n` rises.
- R8: SCK stays high for `sck_div`+1 system clocks and low for `sck_div`+1 system clocks, so one SCK period is 2·(`sck_div`+1) system clocks.
- R9: With `rd`=0, data byte k is `wdata[8k+7:8k]`. With `rd`=1, every data byte sent is 8'h00.
- R10: Data byte k shifted in from MISO appears at `rdata[8k+7:8k]`. Bytes at positions above `len_m1` are 0 after the transaction, and MISO during the address and control bytes is discarded.
- R11: `done` is high for exactly one cycle. In that cycle `busy` is 0, and `ss_n` has already been 1 in the cycle before.
- R12: A start while `busy` is 1 is ignored. The running transaction carries on with its latched command, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_osc | input | 1 | Reference oscillator, asynchronous, used only for gap counting |
| start | input | 1 | Request a transaction (one-cycle pulse) |
| rd | input | 1 | 1: read access, data bytes are sent as zero |
| addr | input | 8 | Address byte |
| ctrl | input | 8 | Control byte |
| len_m1 | input | 4 | Number of data bytes minus one |
| wdata | input | 128 | Data bytes to send, byte k in bits 8k+7:8k |
| sck_div | input | 10 | SCK half period minus one, in system clocks |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | SPI bit clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 128 | Data bytes received, byte k in bits 8k+7:8k |

## Verification
The bench runs four transactions, each against a slave model that answers with its own byte pattern:
- A sixteen-byte write at the fastest practical divider exercises full-length indexing and every data-to-data gap.
- A one-byte read at divider zero shows that zeros are sent and that the stale upper `rdata` bytes are cleared.
- A three-byte write with a second start pulse, and with changed inputs mid-transfer, tells real latching apart from live use of the inputs.
- A two-byte read at the slowest SCK rate shows that the gaps stay tied to the reference oscillator and not to SCK.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_GAP  = 3'd1,
        SEQ_XFER = 3'd2,
        SEQ_TAIL = 3'd3,
        SEQ_FIN  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/spi_gap_sync.sv
module spi_gap_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t y_d, y_q;

    always_comb begin
        y_d    = y_q;
        y_d.s1 = async_in;
        y_d.s2 = y_q.s1;
        y_d.s3 = y_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign rise = y_q.s2 & ~y_q.s3;
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    input  logic             tick,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = val;
        end else if (tick && (t_q.cnt != '0)) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = (t_q.cnt == '0);
endmodule

// File: rtl/spi_gap_shift.sv
module spi_gap_shift #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic [7:0]       rx,
    output logic             fin
);
    typedef struct packed {
        logic             active;
        logic             sck;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] half;
        logic [7:0]       sh;
        logic [7:0]       rx;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (go) begin
            e_d.active = 1'b1;
            e_d.sck    = 1'b0;
            e_d.bitn   = 3'd0;
            e_d.half   = div;
            e_d.sh     = tx;
        end else if (e_q.active) begin
            if (e_q.half != '0) begin
                e_d.half = e_q.half - 1'b1;
            end else begin
                e_d.half = div;
                if (!e_q.sck) begin
                    e_d.sck = 1'b1;
                    e_d.rx  = {e_q.rx[6:0], miso};
                end else begin
                    e_d.sck = 1'b0;
                    if (e_q.bitn == 3'd7) begin
                        e_d.active = 1'b0;
                        e_d.sh     = '0;
                    end else begin
                        e_d.bitn = e_q.bitn + 3'd1;
                        e_d.sh   = {e_q.sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign sck  = e_q.sck;
    assign mosi = e_q.sh[7];
    assign rx   = e_q.rx;
    assign fin  = e_q.active && (e_q.half == '0) && e_q.sck && (e_q.bitn == 3'd7);
endmodule

// File: rtl/spi_gap_seq.sv
module spi_gap_seq
    import spi_gap_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int DIV_W     = 10,
    parameter int GAP_SS    = 4,
    parameter int GAP_ADDR  = 8,
    parameter int GAP_CTRL  = 15,
    parameter int GAP_DATA  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ref_osc,
    input  logic                        start,
    input  logic                        rd,
    input  logic [7:0]                  addr,
    input  logic [7:0]                  ctrl,
    input  logic [$clog2(MAX_BYTES)-1:0] len_m1,
    input  logic [MAX_BYTES*8-1:0]      wdata,
    input  logic [DIV_W-1:0]            sck_div,
    input  logic                        miso,
    output logic                        sck,
    output logic                        mosi,
    output logic                        ss_n,
    output logic                        busy,
    output logic                        done,
    output logic [MAX_BYTES*8-1:0]      rdata
);
    localparam int LEN_W   = $clog2(MAX_BYTES);
    localparam int DATA_W  = MAX_BYTES * 8;
    localparam int IDX_W   = $clog2(MAX_BYTES + 2);
    localparam int GAP_M1  = (GAP_SS > GAP_ADDR) ? GAP_SS : GAP_ADDR;
    localparam int GAP_M2  = (GAP_CTRL > GAP_DATA) ? GAP_CTRL : GAP_DATA;
    localparam int GAP_MAX = (GAP_M1 > GAP_M2) ? GAP_M1 : GAP_M2;
    localparam int CNT_W   = $clog2(GAP_MAX + 3);
    // two extra edges: one may predate the event, one makes the period whole
    localparam logic [CNT_W-1:0] LD_SS   = CNT_W'(GAP_SS + 2);
    localparam logic [CNT_W-1:0] LD_ADDR = CNT_W'(GAP_ADDR + 2);
    localparam logic [CNT_W-1:0] LD_CTRL = CNT_W'(GAP_CTRL + 2);
    localparam logic [CNT_W-1:0] LD_DATA = CNT_W'(GAP_DATA + 2);

    typedef struct packed {
        seq_state_e         st;
        logic               ss_n;
        logic               done;
        logic [IDX_W-1:0]   idx;
        logic [LEN_W-1:0]   last;
        logic               rd;
        logic [7:0]         addr;
        logic [7:0]         ctrl;
        logic [DIV_W-1:0]   div;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic             ref_tick;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             byte_go;
    logic [7:0]       byte_tx;
    logic             byte_fin;
    logic [7:0]       byte_rx;
    logic [LEN_W-1:0] data_idx;
    logic             is_last;
    logic [IDX_W-1:0] cur_idx;

    spi_gap_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_osc),
        .rise     (ref_tick)
    );

    spi_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .val     (tmr_val),
        .tick    (ref_tick),
        .expired (tmr_done)
    );

    spi_gap_shift #(.DIV_W(DIV_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (byte_go),
        .tx   (byte_tx),
        .div  (s_q.div),
        .miso (miso),
        .sck  (sck),
        .mosi (mosi),
        .rx   (byte_rx),
        .fin  (byte_fin)
    );

    assign data_idx = LEN_W'(s_q.idx - IDX_W'(2));
    assign is_last  = (s_q.idx == (IDX_W'(s_q.last) + IDX_W'(2)));
    assign cur_idx  = s_q.idx;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        byte_go  = 1'b0;
        if (s_q.idx == IDX_W'(0))      byte_tx = s_q.addr;
        else if (s_q.idx == IDX_W'(1)) byte_tx = s_q.ctrl;
        else if (s_q.rd)               byte_tx = 8'h00;
        else                           byte_tx = s_q.wdata[{data_idx, 3'b000} +: 8];

        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st    = SEQ_GAP;
                    s_d.ss_n  = 1'b0;
                    s_d.idx   = '0;
                    s_d.last  = len_m1;
                    s_d.rd    = rd;
                    s_d.addr  = addr;
                    s_d.ctrl  = ctrl;
                    s_d.div   = sck_div;
                    s_d.wdata = wdata;
                    s_d.rdata = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SS;
                end
            end
            SEQ_GAP: begin
                if (tmr_done) begin
                    byte_go = 1'b1;
                    s_d.st  = SEQ_XFER;
                end
            end
            SEQ_XFER: begin
                if (byte_fin) begin
                    tmr_load = 1'b1;
                    if (s_q.idx >= IDX_W'(2)) begin
                        s_d.rdata[{data_idx, 3'b000} +: 8] = byte_rx;
                    end
                    if (is_last) begin
                        tmr_val = LD_DATA;
                        s_d.st  = SEQ_TAIL;
                    end else begin
                        if (s_q.idx == IDX_W'(0))      tmr_val = LD_ADDR;
                        else if (s_q.idx == IDX_W'(1)) tmr_val = LD_CTRL;
                        else                           tmr_val = LD_DATA;
                        s_d.idx = s_q.idx + IDX_W'(1);
                        s_d.st  = SEQ_GAP;
                    end
                end
            end
            SEQ_TAIL: begin
                if (tmr_done) begin
                    s_d.ss_n = 1'b1;
                    s_d.st   = SEQ_FIN;
                end
            end
            SEQ_FIN: begin
                s_d.done = 1'b1;
                s_d.st   = SEQ_IDLE;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= SEQ_IDLE;
            s_q.ss_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ss_n  = s_q.ss_n;
    assign busy  = (s_q.st != SEQ_IDLE);
    assign done  = s_q.done;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/spi_gap_seq_chk.sv
module spi_gap_seq_chk #(
    parameter int IDX_W    = 5,
    parameter int GAP_SS   = 4,
    parameter int GAP_ADDR = 8,
    parameter int GAP_CTRL = 15,
    parameter int GAP_DATA = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck,
    input logic             mosi,
    input logic             ss_n,
    input logic             busy,
    input logic             done,
    input logic             ref_tick,
    input logic             tmr_load,
    input logic             byte_go,
    input logic [IDX_W-1:0] idx
);
    logic [5:0] ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ticks_q <= '0;
        else if (tmr_load)                      ticks_q <= '0;
        else if (ref_tick && ticks_q != 6'h3f)  ticks_q <= ticks_q + 6'd1;
    end

    a_r3_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sck);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    a_r3_release_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |=> done);

    a_r4_gap_before_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && idx == IDX_W'(0)) |-> (int'(ticks_q) >= GAP_SS + 1));

    a_r5_gap_before_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && idx == IDX_W'(1)) |-> (int'(ticks_q) >= GAP_ADDR + 1));

    a_r6_gap_before_data0: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && idx == IDX_W'(2)) |-> (int'(ticks_q) >= GAP_CTRL + 1));

    a_r7_gap_between_data: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && idx > IDX_W'(2)) |-> (int'(ticks_q) >= GAP_DATA + 1));

    a_r7_gap_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> (int'(ticks_q) >= GAP_DATA + 1));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n && $past(ss_n) && !busy));

    a_r12_select_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> !$past(busy));
endmodule

bind spi_gap_seq spi_gap_seq_chk #(
    .IDX_W   (IDX_W),
    .GAP_SS  (GAP_SS),
    .GAP_ADDR(GAP_ADDR),
    .GAP_CTRL(GAP_CTRL),
    .GAP_DATA(GAP_DATA)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .ss_n     (ss_n),
    .busy     (busy),
    .done     (done),
    .ref_tick (ref_tick),
    .tmr_load (tmr_load),
    .byte_go  (byte_go),
    .idx      (cur_idx)
);

// File: tb/spi_gap_seq_tb_top.sv
`timescale 1ns/1ps
module spi_gap_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_HALF   = 61;
    localparam int WD_CYCLES  = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_osc = 1'b0;
    logic         start = 1'b0;
    logic         rd = 1'b0;
    logic [7:0]   addr = '0;
    logic [7:0]   ctrl = '0;
    logic [3:0]   len_m1 = '0;
    logic [127:0] wdata = '0;
    logic [9:0]   sck_div = '0;
    logic         miso;
    logic         sck, mosi, ss_n, busy, done;
    logic [127:0] rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(REF_HALF) ref_osc = ~ref_osc;

    spi_gap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ref_osc(ref_osc), .start(start), .rd(rd),
        .addr(addr), .ctrl(ctrl), .len_m1(len_m1), .wdata(wdata),
        .sck_div(sck_div), .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .busy(busy), .done(done), .rdata(rdata)
    );

    // ---------------- bus monitor and slave model ----------------
    int   refcnt = 0;
    int   tot_bits = 0;
    int   ss_fall_ref = 0, ss_fall_tot = 0, ss_fall_cnt = 0;
    int   byte_end_ref = 0, ss_rise_cnt = 0, tail_gap = 0;
    time  last_rise = 0, last_period = 0;
    int         gap_arr  [512];
    logic [7:0] mosi_arr [512];
    logic [7:0] resp_arr [512];

    always @(posedge ref_osc) refcnt++;

    always @(negedge ss_n) begin
        ss_fall_ref = refcnt;
        ss_fall_tot = tot_bits;
        ss_fall_cnt++;
    end

    always @(posedge ss_n) begin
        tail_gap = refcnt - byte_end_ref;
        ss_rise_cnt++;
    end

    always @(posedge sck) begin
        int by;
        by = (tot_bits / 8) % 512;
        if (tot_bits % 8 == 0) begin
            gap_arr[by]  = refcnt - ((tot_bits == ss_fall_tot) ? ss_fall_ref : byte_end_ref);
            mosi_arr[by] = 8'h00;
        end else begin
            last_period = $time - last_rise;
        end
        last_rise    = $time;
        mosi_arr[by] = {mosi_arr[by][6:0], mosi};
        tot_bits++;
    end

    always @(negedge sck) begin
        if (tot_bits % 8 == 0) byte_end_ref = refcnt;
    end

    always_comb begin
        if (ss_n) miso = 1'b0;
        else      miso = resp_arr[(tot_bits / 8) % 512][7 - (tot_bits % 8)];
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(input logic [7:0] a, input int k);
        return a ^ 8'(k * 37 + 11);
    endfunction

    // one full transaction with all per-transaction checks
    task automatic run_txn(input logic [7:0] a, input logic [7:0] c, input int lm1,
                           input bit r, input int dv, input bit poke);
        int base, nb, fall0, rise0, cyc;
        logic prev_ss;
        base  = tot_bits / 8;
        fall0 = ss_fall_cnt;
        rise0 = ss_rise_cnt;
        for (int k = 0; k < lm1 + 3; k++) resp_arr[(base + k) % 512] = 8'hA5 ^ 8'(k * 29) ^ a;
        @(negedge clk);
        addr = a; ctrl = c; len_m1 = 4'(lm1); rd = r; sck_div = 10'(dv);
        for (int k = 0; k < 16; k++) wdata[k*8 +: 8] = wbyte(a, k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (poke) begin
            repeat (60) @(negedge clk);
            addr = ~a; ctrl = ~c; wdata = ~wdata; rd = ~r; len_m1 = 4'd15;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        prev_ss = ss_n;
        while (!done && cyc < 120000) begin
            prev_ss = ss_n;
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R11", "done seen", done, 1);
        chk(ss_n == 1'b1 && prev_ss == 1'b1, "R11", "ss_n high before done",
            {prev_ss, ss_n}, 3);
        chk(busy == 1'b0, "R11", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", done, 0);
        nb = tot_bits / 8 - base;
        chk(nb == lm1 + 3 && tot_bits % 8 == 0, "R2", "bytes in frame", nb, lm1 + 3);
        chk(ss_fall_cnt - fall0 == 1, "R3", "ss_n falls", ss_fall_cnt - fall0, 1);
        chk(ss_rise_cnt - rise0 == 1, "R3", "ss_n rises", ss_rise_cnt - rise0, 1);
        chk(mosi_arr[base % 512] == a, "R2", "address byte", mosi_arr[base % 512], a);
        chk(mosi_arr[(base + 1) % 512] == c, "R2", "control byte", mosi_arr[(base + 1) % 512], c);
        for (int k = 0; k <= lm1; k++) begin
            logic [7:0] ex;
            ex = r ? 8'h00 : wbyte(a, k);
            chk(mosi_arr[(base + 2 + k) % 512] == ex, "R9", "data byte sent",
                mosi_arr[(base + 2 + k) % 512], ex);
            chk(rdata[k*8 +: 8] == resp_arr[(base + 2 + k) % 512], "R10", "data byte received",
                rdata[k*8 +: 8], resp_arr[(base + 2 + k) % 512]);
        end
        for (int k = lm1 + 1; k < 16; k++)
            chk(rdata[k*8 +: 8] == 8'h00, "R10", "unused byte cleared", rdata[k*8 +: 8], 0);
        chk(gap_arr[base % 512] >= 5, "R4", "edges before address", gap_arr[base % 512], 5);
        chk(gap_arr[(base + 1) % 512] >= 9, "R5", "edges before control",
            gap_arr[(base + 1) % 512], 9);
        chk(gap_arr[(base + 2) % 512] >= 16, "R6", "edges before first data",
            gap_arr[(base + 2) % 512], 16);
        for (int k = 3; k < lm1 + 3; k++)
            chk(gap_arr[(base + k) % 512] >= 13, "R7", "edges between data",
                gap_arr[(base + k) % 512], 13);
        chk(tail_gap >= 13, "R7", "edges before release", tail_gap, 13);
        chk(last_period == time'(2 * (dv + 1) * CLK_PERIOD), "R8", "SCK period",
            last_period, 2 * (dv + 1) * CLK_PERIOD);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && ss_n == 1'b1, "R12", "no follow-on transaction",
            {busy, ss_n}, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ss_n == 1'b1, "R1", "ss_n at reset", ss_n, 1);
        chk(sck == 1'b0, "R1", "sck at reset", sck, 0);
        chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
        chk(done == 1'b0, "R1", "done at reset", done, 0);
    endtask

    task automatic test_long_write();   // R2 R9 R10 full length
        run_txn(8'h3C, 8'h81, 15, 1'b0, 1, 1'b0);
    endtask

    task automatic test_short_read();   // R9 zeros sent, R10 stale bytes cleared
        run_txn(8'hC5, 8'h12, 0, 1'b1, 0, 1'b0);
    endtask

    task automatic test_ignored_start(); // R12 second start during transfer
        run_txn(8'h5A, 8'hE7, 2, 1'b0, 3, 1'b1);
    endtask

    task automatic test_slow_read();    // R8 slowest SCK, gaps still held
        run_txn(8'h96, 8'h40, 1, 1'b1, 390, 1'b0);
    endtask

    initial begin
        #(WD_CYCLES * CLK_PERIOD);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_long_write();
        test_short_read();
        test_ignored_start();
        test_slow_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule